// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Burst Tracking

This block decides which of several bus masters owns a shared, pipelined system bus. Every master raises its own request line. The arbiter keeps one owner at a time. It publishes that owner as a one-hot grant vector and as a binary index. Ownership passes on in rotating order, so the master just after the current owner has the highest priority and the current owner has the lowest.

The arbiter watches the transfer type and burst type that the owner drives, together with the global ready. With these it knows when the owner's burst is over. A single transfer ends on its opening beat. A fixed-length burst ends on its last accepted beat. An open-ended incrementing burst ends when the owner lowers its request. Handover happens only at one of these end points. If nobody requests, the grant stays parked on the present owner.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the registers leave reset on the second rising clock edge after the reset pin goes high.

Top module: `rr_burst_arbiter`

## Requirements
- R1: While reset is held, and until the first arbitration edge after release, the owner index is 0 and the grant vector has only bit 0 set.
- R2: Exactly one grant bit is set at every moment, and it is the bit whose position equals the owner index.
- R3: When a handover happens, the new owner is the first requester found by scanning from owner+1 upward and wrapping from N-1 to 0. The current owner is scanned last. If no request line is high, the owner does not change.
- R4: Transfer types are encoded IDLE=00, BUSY=01, NONSEQ=10, SEQ=11, and burst types as SINGLE=000, INCR=001, WRAP4=010, INCR4=011, WRAP8=100, INCR8=101, WRAP16=110, INCR16=111. While no burst is open, a NONSEQ sampled with ready high and burst type SINGLE causes a handover at that same clock edge.
- R5: While no burst is open, a NONSEQ sampled with ready high and a fixed-length burst type opens a burst. The length is 4 beats for types 010/011, 8 beats for 100/101 and 16 beats for 110/111; the wrapping and incrementing forms of a length behave alike. The opening NONSEQ counts as beat 1, and handover happens at the edge that accepts the last beat.
- R6: A beat counts only when ready is high and the transfer type is NONSEQ or SEQ. BUSY, IDLE, or any cycle with ready low leaves the remaining-beat count unchanged.
- R7: A NONSEQ with ready high and burst type INCR (001), sampled while no burst is open, opens an open-ended burst. The owner keeps the bus, whatever the transfers and other requests, until its own request line is sampled low. Handover happens at that edge.
- R8: While a burst is open, requests from other masters and further NONSEQ transfers do not move the grant.
- R9: While no burst is open, an edge that does not sample a NONSEQ with ready high leaves the owner unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| req | input | N_MASTERS | One request line per master |
| bus_ready | input | 1 | Global ready; high means the current beat is accepted |
| bus_trans | input | 2 | Transfer type driven by the current owner |
| bus_burst | input | 3 | Burst type driven by the current owner |
| grant | output | N_MASTERS | One-hot grant vector |
| owner | output | IDX_W | Binary index of the granted master |

## Verification
A wrong beat count or a stuck burst flag shows up only as a grant that moves at the wrong edge. The bench therefore compares the owner index and the grant vector after every edge against a model built from the requirements. A miscount becomes visible at the edge where the burst should have ended, one beat early or late. A bad rotation shows up at the very next handover. A broken one-hot decode shows up in the same cycle as a mismatch between the grant vector and the owner index.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  typedef enum logic [1:0] {
    XFER_IDLE   = 2'b00,
    XFER_BUSY   = 2'b01,
    XFER_NONSEQ = 2'b10,
    XFER_SEQ    = 2'b11
  } xfer_e;

  localparam logic [2:0] BT_SINGLE = 3'b000;
  localparam logic [2:0] BT_INCR   = 3'b001;

  // Wide enough for 15 remaining beats of a 16-beat burst
  localparam int BEAT_W = 4;
  typedef logic [BEAT_W-1:0] beat_t;

  // Beats that remain after the opening beat of a fixed burst
  function automatic beat_t beats_after_first(input logic [2:0] bt);
    case (bt[2:1])
      2'b01:   return beat_t'(3);
      2'b10:   return beat_t'(7);
      2'b11:   return beat_t'(15);
      default: return beat_t'(0);
    endcase
  endfunction

endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rr_burst_tracker.sv
module rr_burst_tracker
  import rr_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_ready,
  input  logic [1:0] bus_trans,
  input  logic [2:0] bus_burst,
  input  logic       owner_req,
  output logic       open_q,
  output logic       incr_q,
  output logic       handover
);
  beat_t left_q, left_d;
  logic  open_d, incr_d;
  logic  beat_ok, opening;

  always_comb begin
    beat_ok  = bus_ready && bus_trans[1];
    opening  = !open_q && bus_ready && (bus_trans == XFER_NONSEQ);
    open_d   = open_q;
    incr_d   = incr_q;
    left_d   = left_q;
    handover = 1'b0;
    if (!open_q) begin
      if (opening) begin
        if (bus_burst == BT_SINGLE) begin
          handover = 1'b1;
        end else if (bus_burst == BT_INCR) begin
          open_d = 1'b1;
          incr_d = 1'b1;
        end else begin
          open_d = 1'b1;
          incr_d = 1'b0;
          left_d = beats_after_first(bus_burst);
        end
      end
    end else if (incr_q) begin
      if (!owner_req) begin
        handover = 1'b1;
        open_d   = 1'b0;
        incr_d   = 1'b0;
      end
    end else if (beat_ok) begin
      if (left_q == beat_t'(1)) begin
        handover = 1'b1;
        open_d   = 1'b0;
      end
      left_d = left_q - beat_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      incr_q <= 1'b0;
      left_q <= '0;
    end else begin
      open_q <= open_d;
      incr_q <= incr_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/rr_next_pick.sv
module rr_next_pick #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [IDX_W-1:0]     cur,
  output logic [IDX_W-1:0]     pick
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = cur;
    for (int step = 1; step <= N_MASTERS; step++) begin
      int cand;
      cand = int'(cur) + step;
      if (cand >= N_MASTERS) cand = cand - N_MASTERS;
      if (!found && req[cand]) begin
        found = 1'b1;
        pick  = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/rr_burst_arbiter.sv
module rr_burst_arbiter
  import rr_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 bus_ready,
  input  logic [1:0]           bus_trans,
  input  logic [2:0]           bus_burst,
  output logic [N_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]     owner
);
  logic             rst_n_int;
  logic             trk_open, trk_incr, trk_handover;
  logic [IDX_W-1:0] owner_q, owner_d, pick;

  rr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  rr_burst_tracker u_trk (
    .clk(clk), .rst_n(rst_n_int),
    .bus_ready(bus_ready), .bus_trans(bus_trans), .bus_burst(bus_burst),
    .owner_req(req[owner_q]),
    .open_q(trk_open), .incr_q(trk_incr), .handover(trk_handover)
  );

  rr_next_pick #(.N_MASTERS(N_MASTERS)) u_pick (.req(req), .cur(owner_q), .pick(pick));

  always_comb begin
    owner_d = owner_q;
    if (trk_handover) owner_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) owner_q <= '0;
    else            owner_q <= owner_d;
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
    assign grant[g] = (owner_q == IDX_W'(g));
  end

  assign owner = owner_q;
endmodule

// File: rtl/rr_burst_arbiter_chk.sv
module rr_burst_arbiter_chk #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input logic                 clk,
  input logic                 rst_n_int,
  input logic [N_MASTERS-1:0] req,
  input logic                 bus_ready,
  input logic [1:0]           bus_trans,
  input logic [2:0]           bus_burst,
  input logic [N_MASTERS-1:0] grant,
  input logic [IDX_W-1:0]     owner,
  input logic                 trk_open,
  input logic                 trk_incr
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($countones(grant) == 1) && grant[owner]);

  p_park_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req == '0) |=> $stable(owner));

  p_single_moves_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!trk_open && bus_ready && bus_trans == 2'b10 && bus_burst == 3'b000 && ((req & ~grant) != '0))
    |=> (owner != $past(owner)));

  p_incr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (trk_open && trk_incr && req[owner]) |=> $stable(owner));

  p_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!trk_open && !(bus_ready && bus_trans == 2'b10)) |=> $stable(owner));

  p_fixed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (trk_open && !trk_incr && !(bus_ready && bus_trans[1])) |=> $stable(owner));
endmodule

bind rr_burst_arbiter rr_burst_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk(clk), .rst_n_int(rst_n_int), .req(req), .bus_ready(bus_ready),
  .bus_trans(bus_trans), .bus_burst(bus_burst), .grant(grant), .owner(owner),
  .trk_open(trk_open), .trk_incr(trk_incr)
);

// File: tb/tb_rr_burst_arbiter.sv
module tb_rr_burst_arbiter;
  localparam int N = 4;
  localparam int IW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          bus_ready;
  logic [1:0]    bus_trans;
  logic [2:0]    bus_burst;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Reference model state
  int m_owner, m_left;
  bit m_open, m_incr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_burst_arbiter #(.N_MASTERS(N)) dut (.*);

  function automatic int next_owner(input int cur, input logic [N-1:0] r);
    for (int s = 1; s <= N; s++) begin
      int c;
      c = (cur + s) % N;
      if (r[c]) return c;
    end
    return cur;
  endfunction

  function automatic int fixed_len(input logic [2:0] b);
    return (b[2:1] == 2'b01) ? 4 : (b[2:1] == 2'b10) ? 8 : 16;
  endfunction

  task automatic check(input string tag);
    logic [N-1:0] eg;
    eg = N'(1) << m_owner;
    n_chk++;
    if (int'(owner) != m_owner || grant != eg) begin
      n_bad++;
      $display("FAIL %s: owner=%0d grant=%b expected owner=%0d grant=%b",
               tag, owner, grant, m_owner, eg);
    end
  endtask

  // Drive one cycle at the falling edge, advance the model, sample after the rising edge
  task automatic step(input logic [N-1:0] r, input logic rdy, input logic [1:0] t,
                      input logic [2:0] b, input string tag);
    bit ho;
    @(negedge clk);
    req = r; bus_ready = rdy; bus_trans = t; bus_burst = b;
    ho = 0;
    if (!m_open) begin
      if (rdy && t == 2'b10) begin
        if (b == 3'b000) ho = 1;
        else if (b == 3'b001) begin m_open = 1; m_incr = 1; end
        else begin m_open = 1; m_incr = 0; m_left = fixed_len(b) - 1; end
      end
    end else if (m_incr) begin
      if (!r[m_owner]) begin ho = 1; m_open = 0; m_incr = 0; end
    end else if (rdy && t[1]) begin
      m_left--;
      if (m_left == 0) begin ho = 1; m_open = 0; end
    end
    if (ho) m_owner = next_owner(m_owner, r);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_owner = 0; m_open = 0; m_incr = 0; m_left = 0;
    rst_n = 0; req = '1; bus_ready = 1; bus_trans = 2'b10; bus_burst = 3'b000;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 check("R1 after release");
    // Internal release lands on the following edge; keep inputs neutral
    step('1, 1'b1, 2'b00, 3'b000, "R1 idle after release");

    // R4 / R3: singles with every master requesting rotate 0->1->2->3->0
    for (int i = 0; i < 4; i++) step('1, 1'b1, 2'b10, 3'b000, "R4 single rotation");
    // R3: only master 2 requesting, from owner 0
    step(4'b0100, 1'b1, 2'b10, 3'b000, "R3 skip to sole requester");
    step(4'b0100, 1'b1, 2'b10, 3'b000, "R3 owner rescanned last");
    step(4'b0000, 1'b1, 2'b10, 3'b000, "R3 park with no requests");
    // R3 wrap: owner 2, requests on 1 only
    step(4'b0010, 1'b1, 2'b10, 3'b000, "R3 wrap past top index");
    // R9: free bus, non-NONSEQ or not ready
    step('1, 1'b1, 2'b00, 3'b000, "R9 idle keeps owner");
    step('1, 1'b0, 2'b10, 3'b000, "R9 not ready keeps owner");
    step('1, 1'b1, 2'b11, 3'b000, "R9 seq while free keeps owner");

    // R5 / R6 / R8: INCR4 with BUSY and wait states
    step('1, 1'b1, 2'b10, 3'b011, "R5 open incr4");
    step('1, 1'b1, 2'b01, 3'b011, "R6 busy does not count");
    step('1, 1'b0, 2'b11, 3'b011, "R6 wait state does not count");
    step('1, 1'b1, 2'b11, 3'b011, "R5 beat 2");
    step('1, 1'b1, 2'b10, 3'b011, "R8 nonseq mid burst counts, no move");
    step('1, 1'b1, 2'b11, 3'b011, "R5 last beat hands over");
    // R5: WRAP16 length
    step('1, 1'b1, 2'b10, 3'b110, "R5 open wrap16");
    for (int i = 0; i < 15; i++) step('1, 1'b1, 2'b11, 3'b110, "R5 wrap16 beats");
    // R5: WRAP8
    step('1, 1'b1, 2'b10, 3'b100, "R5 open wrap8");
    for (int i = 0; i < 7; i++) step('1, 1'b1, 2'b11, 3'b100, "R5 wrap8 beats");

    // R7: INCR held until owner drops request
    step('1, 1'b1, 2'b10, 3'b001, "R7 open incr");
    for (int i = 0; i < 20; i++) step('1, 1'b1, 2'b11, 3'b001, "R7 held while requesting");
    step('1, 1'b1, 2'b10, 3'b000, "R8 nonseq in incr no move");
    begin
      logic [N-1:0] r;
      r = '1; r[m_owner] = 1'b0;
      step(r, 1'b1, 2'b00, 3'b001, "R7 release on request drop");
    end

    // Random traffic, owner request mostly held
    for (int i = 0; i < 6000; i++) begin
      logic [N-1:0] r;
      logic [1:0] t;
      r = N'($urandom);
      if (($urandom % 10) != 0) r[m_owner] = 1'b1;
      t = m_open ? ((($urandom % 4) == 0) ? 2'(($urandom % 4)) : 2'b11) : 2'(($urandom % 4));
      step(r, (($urandom % 5) != 0), t, 3'($urandom), "R2 random traffic");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule